// File: doc/BRIEF.md
# Request-Driven Serial Frame Transmitter

This block holds a 64-bit output buffer and sends part of it to an external controller over one serial data line. The controller owns the timing: it supplies the shift clock and a transmit-request level. The block owns the data-ready flag. A processor-side port writes the buffer with a single-cycle load strobe, and that write raises data-ready.

A frame starts when the controller holds its request high while data-ready is high and then gives a rising shift-clock edge. Each rising edge moves one bit onto the line. The first 48 edges present the upper 48 buffer bits, most significant bit first, so the six bytes leave with the top byte first. The 49th edge presents an odd-parity bit. At that point the block pulses an interrupt so the processor can reload the buffer. The lowest 16 buffer bits are never sent.

The shift clock and the request come from another clock domain. Each passes through a two-flop synchroniser. Edges are found on the synchronised shift clock. If the request drops before the frame completes, the block abandons the frame, returns to idle and raises no interrupt. Data-ready stays low until the next load.

Top module: `req_serial_tx`

## Requirements
- R1: After synchronous reset, data_ready, ser_out and frame_irq are all 0.
- R2: A load_stb pulse while no frame is in progress stores load_data and sets data_ready to 1 on the next clock. data_ready never rises without such a load.
- R3: Shift-clock rising edges do not change ser_out or data_ready when xfer_req is low or data_ready is low.
- R4: Within a frame, each rising edge of ser_clk presents the next bit on ser_out. ser_out changes on the third system clock after ser_clk rises. Edges 1 to 48 present load_data bits 63 down to 16 in that order, so the byte in bits 63:56 goes first.
- R5: The 49th edge presents the parity bit. Its value makes the count of ones over the 48 data bits plus the parity bit odd.
- R6: Only 49 bits are sent. Further ser_clk edges after the parity bit leave ser_out unchanged, so bits 15:0 are never sent.
- R7: data_ready falls at the first shifted bit and stays low for the rest of the frame.
- R8: frame_irq pulses high for exactly one system clock, once per completed frame, in the same cycle that the parity bit appears.
- R9: If xfer_req is low at the synchroniser output during a frame, the frame is abandoned. No interrupt follows, data_ready stays low, and later ser_clk edges do not change ser_out until a new load.
- R10: A load_stb pulse during a frame is ignored. The remaining bits still come from the original buffer, and data_ready stays low.
- R11: After a completed frame, ser_out holds the parity bit until the next load. A load drives ser_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_stb | input | 1 | Single-cycle buffer write strobe from the processor side |
| load_data | input | 64 | Buffer contents written on load_stb |
| xfer_req | input | 1 | Transmit request from the controller (asynchronous level) |
| ser_clk | input | 1 | Shift clock from the controller (asynchronous) |
| data_ready | output | 1 | Buffer loaded and not yet sent |
| ser_out | output | 1 | Serial data line |
| frame_irq | output | 1 | One-cycle end-of-frame interrupt |

## Verification
A bit counter that slips or a buffer that shifts one place too many would show up directly on ser_out. Every bit after the fault comes out wrong, and the parity bit would arrive early or late, within one shift-clock period of the fault. A sequencer stuck in the busy state would leave data_ready low after a load and show no frame_irq at the 49th edge. A sequencer that returns to idle too early would drop the parity bit or miss the abort. The scoreboard compares every presented bit against the loaded word, so each fault surfaces at the first wrong edge.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
    localparam int BUF_W     = 64;
    localparam int WORD_W    = 8;
    localparam int WORD_CNT  = 6;
    localparam int DATA_BITS = WORD_W * WORD_CNT;
    localparam int CNT_W     = $clog2(DATA_BITS + 2);

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } tx_state_e;

    // Commands issued by the sequencer to the buffer datapath.
    typedef struct packed {
        logic load;
        logic shift;
        logic parity;
    } shift_cmd_t;

    // Odd parity: the returned bit makes the total count of ones odd.
    function automatic logic odd_parity(input logic [DATA_BITS-1:0] d);
        return ~(^d);
    endfunction
endpackage

// File: rtl/rtx_sync.sv
module rtx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rtx_shifter.sv
module rtx_shifter
    import rtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  shift_cmd_t       cmd,
    input  logic [BUF_W-1:0] load_data,
    output logic             ser_out
);
    logic [BUF_W-1:0] buf_q;
    logic             par_q;
    logic             out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            par_q <= 1'b0;
            out_q <= 1'b0;
        end else if (cmd.load) begin
            buf_q <= load_data;
            par_q <= odd_parity(load_data[BUF_W-1 -: DATA_BITS]);
            out_q <= 1'b0;
        end else if (cmd.shift) begin
            out_q <= buf_q[BUF_W-1];
            buf_q <= {buf_q[BUF_W-2:0], 1'b0};
        end else if (cmd.parity) begin
            out_q <= par_q;
        end
    end

    assign ser_out = out_q;

    assert_cmd_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.load, cmd.shift, cmd.parity}));
endmodule

// File: rtl/rtx_ctrl.sv
module rtx_ctrl
    import rtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_s,
    input  logic       req_s,
    input  logic       load_stb,
    output shift_cmd_t cmd,
    output logic       data_ready,
    output logic       frame_irq
);
    tx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sclk_prev_q;
    logic             ready_q;
    logic             irq_q;

    logic sclk_rise, start, abort, step, last;

    always_comb begin
        sclk_rise  = sclk_s & ~sclk_prev_q;
        start      = (state_q == ST_IDLE) && ready_q && req_s && sclk_rise;
        abort      = (state_q == ST_SHIFT) && !req_s;
        step       = (state_q == ST_SHIFT) && req_s && sclk_rise;
        last       = step && (cnt_q == CNT_W'(DATA_BITS));
        cmd.shift  = start || (step && !last);
        cmd.parity = last;
        cmd.load   = load_stb && (state_q == ST_IDLE) && !start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            sclk_prev_q <= 1'b0;
            ready_q     <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_s;
            irq_q       <= last;
            if (start)         ready_q <= 1'b0;
            else if (cmd.load) ready_q <= 1'b1;
            if (start) begin
                state_q <= ST_SHIFT;
                cnt_q   <= CNT_W'(1);
            end else if (abort || last) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
            end else if (step) begin
                cnt_q   <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign data_ready = ready_q;
    assign frame_irq  = irq_q;

    assert_ready_low_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT) |-> !data_ready);
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
        frame_irq |=> !frame_irq);
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_SHIFT) && !req_s) |=> ((state_q == ST_IDLE) && !frame_irq && !data_ready));
    assert_load_sets_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (load_stb && (state_q == ST_IDLE) && !req_s) |=> data_ready);
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DATA_BITS));
endmodule

// File: rtl/req_serial_tx.sv
module req_serial_tx
    import rtx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_stb,
    input  logic [BUF_W-1:0] load_data,
    input  logic             xfer_req,
    input  logic             ser_clk,
    output logic             data_ready,
    output logic             ser_out,
    output logic             frame_irq
);
    logic       sclk_s;
    logic       req_s;
    shift_cmd_t cmd;

    rtx_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
        .clk(clk), .rst(rst), .async_in(ser_clk), .sync_out(sclk_s)
    );

    rtx_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(clk), .rst(rst), .async_in(xfer_req), .sync_out(req_s)
    );

    rtx_ctrl u_ctrl (
        .clk(clk), .rst(rst), .sclk_s(sclk_s), .req_s(req_s),
        .load_stb(load_stb), .cmd(cmd),
        .data_ready(data_ready), .frame_irq(frame_irq)
    );

    rtx_shifter u_shifter (
        .clk(clk), .rst(rst), .cmd(cmd),
        .load_data(load_data), .ser_out(ser_out)
    );

    assert_irq_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
        frame_irq |-> !data_ready);
endmodule

// File: tb/test_req_serial_tx.sv
`timescale 1ns/1ps
module test_req_serial_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_stb = 1'b0;
    logic [63:0] load_data = '0;
    logic        xfer_req = 1'b0;
    logic        ser_clk = 1'b0;
    logic        data_ready, ser_out, frame_irq;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    int irq_wide = 0;
    logic irq_prev = 1'b0;

    typedef struct {
        logic exp;
        int   idx;
    } exp_bit_t;
    exp_bit_t sb_q[$];

    always #10 clk = ~clk;

    req_serial_tx i_req_serial_tx (
        .clk(clk), .rst(rst), .load_stb(load_stb), .load_data(load_data),
        .xfer_req(xfer_req), .ser_clk(ser_clk),
        .data_ready(data_ready), .ser_out(ser_out), .frame_irq(frame_irq)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst) begin
            if (frame_irq) irq_cnt++;
            if (frame_irq && irq_prev) irq_wide++;
        end
        irq_prev <= frame_irq;
    end

    // Monitor: after each presented bit, compare against the scoreboard head.
    always @(negedge ser_clk) begin
        if (sb_q.size() > 0) begin
            exp_bit_t e;
            e = sb_q.pop_front();
            if (e.idx == 48)
                check(ser_out === e.exp, "R5", "parity bit", 64'(ser_out), 64'(e.exp));
            else
                check(ser_out === e.exp, "R4", $sformatf("data bit %0d", e.idx),
                      64'(ser_out), 64'(e.exp));
        end
    end

    task automatic pulse_sclk();
        @(negedge clk) ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_load(input logic [63:0] d);
        @(negedge clk);
        load_data = d;
        load_stb  = 1'b1;
        @(negedge clk);
        load_stb  = 1'b0;
    endtask

    function automatic logic exp_bit(input logic [63:0] d, input int i);
        if (i < 48) return d[63-i];
        return ~(^d[63:16]);
    endfunction

    // Driver: pushes expected bits and clocks them out; nbits < 49 leaves the frame open.
    task automatic send_frame(input logic [63:0] d, input int nbits, input logic mid_load);
        for (int i = 0; i < nbits; i++) begin
            sb_q.push_back('{exp: exp_bit(d, i), idx: i});
            pulse_sclk();
            if (i == 0)
                check(data_ready === 1'b0, "R7", "ready after first bit", 64'(data_ready), 64'd0);
            if (mid_load && i == 20) begin
                do_load(~d);
                @(negedge clk);
                check(data_ready === 1'b0, "R10", "ready after load in frame", 64'(data_ready), 64'd0);
            end
        end
    endtask

    task automatic full_frame(input logic [63:0] d, input logic mid_load);
        int irq_before;
        irq_before = irq_cnt;
        do_load(d);
        @(negedge clk);
        check(data_ready === 1'b1, "R2", "ready after load", 64'(data_ready), 64'd1);
        check(ser_out === 1'b0, "R11", "line after load", 64'(ser_out), 64'd0);
        xfer_req = 1'b1;
        repeat (4) @(negedge clk);
        send_frame(d, 49, mid_load);
        check(irq_cnt == irq_before + 1, "R8", "irq count per frame", 64'(irq_cnt), 64'(irq_before + 1));
        check(ser_out === exp_bit(d, 48), "R11", "parity held", 64'(ser_out), 64'(exp_bit(d, 48)));
        pulse_sclk();
        pulse_sclk();
        check(ser_out === exp_bit(d, 48), "R6", "no 50th bit", 64'(ser_out), 64'(exp_bit(d, 48)));
        check(irq_cnt == irq_before + 1, "R6", "no extra irq", 64'(irq_cnt), 64'(irq_before + 1));
        check(data_ready === 1'b0, "R2", "ready low after frame", 64'(data_ready), 64'd0);
        xfer_req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(data_ready === 1'b0, "R1", "reset ready", 64'(data_ready), 64'd0);
        check(ser_out === 1'b0, "R1", "reset line", 64'(ser_out), 64'd0);
        check(frame_irq === 1'b0, "R1", "reset irq", 64'(frame_irq), 64'd0);

        // No request, no load.
        pulse_sclk();
        pulse_sclk();
        check(ser_out === 1'b0, "R3", "edges without request", 64'(ser_out), 64'd0);
        // Request but never loaded.
        xfer_req = 1'b1;
        repeat (4) @(negedge clk);
        pulse_sclk();
        check(ser_out === 1'b0, "R3", "edges without ready", 64'(ser_out), 64'd0);
        check(data_ready === 1'b0, "R2", "no ready without load", 64'(data_ready), 64'd0);
        xfer_req = 1'b0;
        repeat (4) @(negedge clk);
        // Loaded but no request.
        do_load(64'hFFFF_FFFF_FFFF_FFFF);
        pulse_sclk();
        @(negedge clk);
        check(ser_out === 1'b0, "R3", "loaded, no request", 64'(ser_out), 64'd0);
        check(data_ready === 1'b1, "R3", "ready kept without request", 64'(data_ready), 64'd1);

        full_frame(64'hA5C3_1E7F_0092_BEEF, 1'b1);
        full_frame(64'h0000_0000_0000_FFFF, 1'b0);
        full_frame(64'hFFFF_FFFF_FFFF_0000, 1'b0);
        full_frame(64'h8000_0000_0001_1234, 1'b0);

        // Abort partway through.
        begin
            int irq_before;
            logic held;
            irq_before = irq_cnt;
            do_load(64'h3C5A_9612_F00D_4321);
            xfer_req = 1'b1;
            repeat (4) @(negedge clk);
            send_frame(64'h3C5A_9612_F00D_4321, 10, 1'b0);
            xfer_req = 1'b0;
            repeat (6) @(negedge clk);
            held = ser_out;
            check(irq_cnt == irq_before, "R9", "no irq on abort", 64'(irq_cnt), 64'(irq_before));
            check(data_ready === 1'b0, "R9", "ready low after abort", 64'(data_ready), 64'd0);
            xfer_req = 1'b1;
            repeat (4) @(negedge clk);
            pulse_sclk();
            pulse_sclk();
            check(ser_out === held, "R9", "no shift after abort", 64'(ser_out), 64'(held));
            check(irq_cnt == irq_before, "R9", "no irq after abort edges", 64'(irq_cnt), 64'(irq_before));
            xfer_req = 1'b0;
            repeat (4) @(negedge clk);
        end
        full_frame(64'h1357_9BDF_2468_ACE0, 1'b0);

        check(irq_wide == 0, "R8", "irq width one cycle", 64'(irq_wide), 64'd0);
        check(sb_q.size() == 0, "R4", "all expected bits seen", 64'(sb_q.size()), 64'd0);
        finish_run();
    end
endmodule